// File: doc/BRIEF.md
# Pipelined CORDIC Sine and Cosine Unit

This block computes the sine and cosine of a signed angle with a chain of CORDIC micro-rotations in circular rotation mode. The angle arrives as a 14-bit two's-complement number in radians with 128 codes per radian. The two results leave as 13-bit two's-complement numbers with 128 codes per unit. The starting vector has x set to the reciprocal of the CORDIC gain and y set to zero. After the last stage x holds the cosine and y holds the sine, so no scaling multiplier follows the chain.

Each micro-rotation sits in its own register rank, behind one rank that captures the input. The unit takes a fresh angle on every rising clock edge and returns one result per clock. Each result follows its angle by a fixed latency. The reset is asynchronous and active low, and it clears every rank.

Top module: `sincos_cordic`

## Requirements
- R1: The angle input is two's complement with 128 codes per radian. Every code from -201 to +201 (about -90 to +90 degrees) is a valid operand.
- R2: For each valid angle a, sin_o lies within 3 LSB of 128*sin(a/128) and cos_o lies within 3 LSB of 128*cos(a/128). Both outputs are two's complement with 128 codes per unit.
- R3: An angle present at rising edge k appears as a result on the outputs after edge k+8, the ninth edge counting edge k.
- R4: A new angle may be applied on every clock, and each result depends only on its own angle.
- R5: While rst_n is low, both outputs read zero at once, with no clock edge needed.
- R6: After rst_n rises, both outputs stay zero for the first eight rising edges, until the first result arrives.
- R7: For any valid angle the cosine output is never below -3.
- R8: When the angle is at least +16 the sine output is positive. When the angle is at most -16 the sine output is negative.
- R9: For every result, sin_o squared plus cos_o squared lies between 15000 and 17500.
- R10: The end points give sin = +128 and cos = 0 for +201, sin = -128 and cos = 0 for -201, and sin = -64 and cos = 111 for -67. Each value has a tolerance of 3 LSB.
- R11: Neither output exceeds a magnitude of 130, and no internal vector component or rounded result overflows its word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| angle_i | input | 14 | Angle in radians, two's complement, 128 codes per radian |
| sin_o | output | 13 | Sine, two's complement, 128 codes per unit |
| cos_o | output | 13 | Cosine, two's complement, 128 codes per unit |

## Verification
Some properties are checked on every cycle once the pipeline has filled:
- the result lies on the unit circle within tolerance;
- the cosine is not negative;
- the sine sign agrees with the angle sign, tracked along the pipeline;
- the residual angle has converged;
- no internal word overflows.

Numerical accuracy against a real-valued model can only be shown by the bench's scenarios. The same holds for the exact latency, the zero outputs while the pipeline fills and the instant effect of the asynchronous reset. The bench covers these with an ascending sweep of every valid angle, an alternating high/low sweep that changes the angle sharply on every clock, and a short list of end points.

// File: rtl/sincos_pkg.sv
package sincos_pkg;

  // arctan(2^-idx) in units of 2^-15 rad
  function automatic int atan_q15(input int idx);
    case (idx)
      0:  return 25736;
      1:  return 15193;
      2:  return 8027;
      3:  return 4075;
      4:  return 2045;
      5:  return 1024;
      6:  return 512;
      7:  return 256;
      8:  return 128;
      9:  return 64;
      10: return 32;
      11: return 16;
      12: return 8;
      13: return 4;
      14: return 2;
      15: return 1;
      default: return 0;
    endcase
  endfunction

  // rescale a Q15 constant to 'frac' fractional bits with rounding
  function automatic int rescale_q15(input int v, input int frac);
    if (frac >= 15) return v;
    return (v + (1 << (14 - frac))) >>> (15 - frac);
  endfunction

  function automatic int atan_q(input int idx, input int frac);
    return rescale_q15(atan_q15(idx), frac);
  endfunction

  // reciprocal of the CORDIC gain, 0.6072529 in Q15
  function automatic int kinv_q(input int frac);
    return rescale_q15(19899, frac);
  endfunction

endpackage

// File: rtl/sincos_load.sv
module sincos_load #(
  parameter int ANG_W = 14,
  parameter int IW    = 19,
  parameter int GUARD = 4,
  parameter int KINV  = 1244
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic signed [ANG_W-1:0] ang_i,
  output logic signed [IW-1:0] x_o,
  output logic signed [IW-1:0] y_o,
  output logic signed [IW-1:0] z_o
);
  logic signed [IW-1:0] x_d, y_d, z_d;

  always_comb begin
    x_d = IW'(KINV);
    y_d = '0;
    z_d = {{(IW-ANG_W){ang_i[ANG_W-1]}}, ang_i} << GUARD;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x_o <= '0;
      y_o <= '0;
      z_o <= '0;
    end else begin
      x_o <= x_d;
      y_o <= y_d;
      z_o <= z_d;
    end
  end
endmodule

// File: rtl/sincos_rot.sv
module sincos_rot #(
  parameter int IW    = 19,
  parameter int SHIFT = 0,
  parameter int ATAN  = 1609,
  parameter int LIMIT = 2560
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic signed [IW-1:0] x_i,
  input  logic signed [IW-1:0] y_i,
  input  logic signed [IW-1:0] z_i,
  output logic signed [IW-1:0] x_o,
  output logic signed [IW-1:0] y_o,
  output logic signed [IW-1:0] z_o
);
  localparam logic signed [IW-1:0] STEP = IW'(ATAN);

  logic signed [IW-1:0] x_sh, y_sh, x_d, y_d, z_d;
  logic                 ccw;

  always_comb begin
    x_sh = x_i >>> SHIFT;
    y_sh = y_i >>> SHIFT;
    ccw  = ~z_i[IW-1];
    if (ccw) begin
      x_d = x_i - y_sh;
      y_d = y_i + x_sh;
      z_d = z_i - STEP;
    end else begin
      x_d = x_i + y_sh;
      y_d = y_i - x_sh;
      z_d = z_i + STEP;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x_o <= '0;
      y_o <= '0;
      z_o <= '0;
    end else begin
      x_o <= x_d;
      y_o <= y_d;
      z_o <= z_d;
    end
  end

  // R11
  xy_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (x_o <= LIMIT) && (x_o >= -LIMIT) && (y_o <= LIMIT) && (y_o >= -LIMIT));
endmodule

// File: rtl/sincos_round.sv
module sincos_round #(
  parameter int IW    = 19,
  parameter int OUT_W = 13,
  parameter int GUARD = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic signed [IW-1:0]    v_i,
  output logic signed [OUT_W-1:0] q_o
);
  localparam logic signed [IW-1:0] HALF = IW'(1 << (GUARD-1));

  logic signed [IW-1:0] r;

  assign r   = (v_i + HALF) >>> GUARD;
  assign q_o = r[OUT_W-1:0];

  // R11
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (r[IW-1:OUT_W-1] == '0) || (r[IW-1:OUT_W-1] == '1));
endmodule

// File: rtl/sincos_cordic.sv
module sincos_cordic #(
  parameter int ANG_W  = 14,
  parameter int OUT_W  = 13,
  parameter int FRAC   = 7,
  parameter int GUARD  = 4,
  parameter int STAGES = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic signed [ANG_W-1:0] angle_i,
  output logic signed [OUT_W-1:0] sin_o,
  output logic signed [OUT_W-1:0] cos_o
);
  localparam int IFRAC     = FRAC + GUARD;
  localparam int IW        = ANG_W + GUARD + 1;
  localparam int LAT       = STAGES + 1;
  localparam int LIMIT     = (1 << IFRAC) + (1 << (IFRAC - 2));
  localparam int ATAN_LAST = sincos_pkg::atan_q(STAGES - 1, IFRAC);
  localparam int SIGN_MIN  = 1 << (FRAC - 3);
  localparam int CW        = $clog2(LAT + 1);

  logic signed [IW-1:0] xs [0:STAGES];
  logic signed [IW-1:0] ys [0:STAGES];
  logic signed [IW-1:0] zs [0:STAGES];

  sincos_load #(
    .ANG_W(ANG_W), .IW(IW), .GUARD(GUARD), .KINV(sincos_pkg::kinv_q(IFRAC))
  ) u_load (
    .clk(clk), .rst_n(rst_n), .ang_i(angle_i),
    .x_o(xs[0]), .y_o(ys[0]), .z_o(zs[0])
  );

  for (genvar g = 0; g < STAGES; g++) begin : g_rot
    sincos_rot #(
      .IW(IW), .SHIFT(g), .ATAN(sincos_pkg::atan_q(g, IFRAC)), .LIMIT(LIMIT)
    ) u_rot (
      .clk(clk), .rst_n(rst_n),
      .x_i(xs[g]),   .y_i(ys[g]),   .z_i(zs[g]),
      .x_o(xs[g+1]), .y_o(ys[g+1]), .z_o(zs[g+1])
    );
  end

  sincos_round #(.IW(IW), .OUT_W(OUT_W), .GUARD(GUARD)) u_rnd_cos (
    .clk(clk), .rst_n(rst_n), .v_i(xs[STAGES]), .q_o(cos_o)
  );

  sincos_round #(.IW(IW), .OUT_W(OUT_W), .GUARD(GUARD)) u_rnd_sin (
    .clk(clk), .rst_n(rst_n), .v_i(ys[STAGES]), .q_o(sin_o)
  );

  // ---- checker state: pipeline fill count and angle sign history ----
  logic [CW-1:0]  fill_q, fill_d;
  logic [LAT-1:0] pos_q, neg_q, pos_d, neg_d;
  logic           filled;
  int             sin_w, cos_w, mag2, z_last;

  always_comb begin
    fill_d = (fill_q == CW'(LAT)) ? fill_q : fill_q + 1'b1;
    pos_d  = {pos_q[LAT-2:0], (angle_i >= ANG_W'(SIGN_MIN))};
    neg_d  = {neg_q[LAT-2:0], (angle_i <= -ANG_W'(SIGN_MIN))};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fill_q <= '0;
      pos_q  <= '0;
      neg_q  <= '0;
    end else begin
      fill_q <= fill_d;
      pos_q  <= pos_d;
      neg_q  <= neg_d;
    end
  end

  assign filled = (fill_q == CW'(LAT));
  assign sin_w  = int'(sin_o);
  assign cos_w  = int'(cos_o);
  assign mag2   = sin_w * sin_w + cos_w * cos_w;
  assign z_last = int'(zs[STAGES]);

  // R5
  always @(posedge clk) begin
    if (!rst_n) begin
      rst_zero_chk: assert (sin_o == '0 && cos_o == '0);
    end
  end

  // R9
  unit_circle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    filled |-> (mag2 >= 15000 && mag2 <= 17500));

  // R7
  cos_nonneg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    filled |-> (cos_w >= -3));

  // R8
  sin_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (filled && pos_q[LAT-1]) |-> (sin_w > 0));

  // R8
  sin_sign_neg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (filled && neg_q[LAT-1]) |-> (sin_w < 0));

  // R2
  residual_chk: assert property (@(posedge clk) disable iff (!rst_n)
    filled |-> (z_last <= 2*ATAN_LAST + STAGES && z_last >= -(2*ATAN_LAST + STAGES)));
endmodule

// File: tb/sincos_cordic_tb.sv
module sincos_cordic_tb;
  localparam int LAT = 9;

  logic               clk;
  logic               rst_n;
  logic signed [13:0] ang;
  logic signed [12:0] sin_v, cos_v;

  int  errs;
  int  checks;
  bit  done;
  int  drv [0:1023];

  sincos_cordic u_dut (
    .clk(clk), .rst_n(rst_n), .angle_i(ang), .sin_o(sin_v), .cos_o(cos_v)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string tag, input int act, input real exp, input real tol);
    real d;
    checks++;
    d = real'(act) - exp;
    if (d > tol || -d > tol) begin
      errs++;
      $display("FAIL %s: actual=%0d expected=%0.2f", tag, act, exp);
    end
  endtask

  function automatic int pick(input int kind, input int m);
    if (kind == 0) return -201 + m;
    if (kind == 1) return (m % 2 == 0) ? 201 - m / 2 : -201 + m / 2;
    case (m)
      0: return -67;
      1: return 201;
      2: return -201;
      3: return 0;
      4: return 16;
      default: return -16;
    endcase
  endfunction

  task automatic check_result(input int a);
    real es, ec;
    int  s, c;
    s  = int'(sin_v);
    c  = int'(cos_v);
    es = $sin(real'(a) / 128.0) * 128.0;   // R1 scaling of the angle
    ec = $cos(real'(a) / 128.0) * 128.0;
    chk("R2 sin", s, es, 3.0);
    chk("R2 cos", c, ec, 3.0);
    chk("R7 cos floor", (c >= -3) ? 1 : 0, 1.0, 0.0);
    chk("R9 magnitude", (s*s + c*c >= 15000 && s*s + c*c <= 17500) ? 1 : 0, 1.0, 0.0);
    chk("R11 range", (s <= 130 && s >= -130 && c <= 130 && c >= -130) ? 1 : 0, 1.0, 0.0);
    if (a >= 16) chk("R8 sin positive", (s > 0) ? 1 : 0, 1.0, 0.0);
    if (a <= -16) chk("R8 sin negative", (s < 0) ? 1 : 0, 1.0, 0.0);
    if (a == 201) begin
      chk("R10 +90 sin", s, 128.0, 3.0);
      chk("R10 +90 cos", c, 0.0, 3.0);
    end
    if (a == -201) begin
      chk("R10 -90 sin", s, -128.0, 3.0);
      chk("R10 -90 cos", c, 0.0, 3.0);
    end
    if (a == -67) begin
      chk("R10 -30 sin", s, -64.0, 3.0);
      chk("R10 -30 cos", c, 111.0, 3.0);
    end
  endtask

  // R3 R4 R6: reset, release, then stream n angles, one per clock
  task automatic stream(input int kind, input int n);
    rst_n = 1'b0;
    ang   = '0;
    @(negedge clk);
    chk("R5 sin in reset", int'(sin_v), 0.0, 0.0);
    chk("R5 cos in reset", int'(cos_v), 0.0, 0.0);
    rst_n  = 1'b1;
    drv[0] = pick(kind, 0);
    ang    = 14'(drv[0]);
    for (int m = 1; m < n + LAT; m++) begin
      @(negedge clk);
      if (m < LAT) begin
        chk("R6 sin during fill", int'(sin_v), 0.0, 0.0);
        chk("R6 cos during fill", int'(cos_v), 0.0, 0.0);
      end else begin
        check_result(drv[m - LAT]);   // R3 alignment, R4 per-clock results
      end
      drv[m] = (m < n) ? pick(kind, m) : 0;
      ang    = 14'(drv[m]);
    end
  endtask

  initial begin
    errs   = 0;
    checks = 0;
    done   = 1'b0;
    rst_n  = 1'b0;
    ang    = '0;
    repeat (3) @(negedge clk);

    stream(0, 403);
    stream(1, 403);
    stream(2, 6);

    // R5: asynchronous clear between clock edges, cos was 128 just before
    @(negedge clk);
    chk("R5 cos before clear", int'(cos_v), 128.0, 3.0);
    #3 rst_n = 1'b0;
    #1;
    chk("R5 sin async clear", int'(sin_v), 0.0, 0.0);
    chk("R5 cos async clear", int'(cos_v), 0.0, 0.0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errs++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule